// File: doc/BRIEF.md
# Shared Address/Data Bus Peripheral Slave

This block sits on the external bus of a microcontroller whose upper address bits and data travel over the same sixteen pins. A latch-strobe cycle captures the upper address from those pins. The bottom four address bits arrive on pins of their own and are used live on every access. A code-read strobe fetches from a code area, a read-only pattern held in logic. The ordinary read and write strobes reach a small data RAM. The block drives read data back onto the shared pins through per-byte-lane output enables. At all other times it releases the pins.

The bus is 8 or 16 bits wide, selected by a mode pin that is sampled only during reset. In 8-bit mode the pins carry address bits 11:4 and one data byte. In 16-bit mode they carry address bits 19:4 and a data word, and a high-byte enable combined with address bit 0 chooses the byte lanes a write touches. Because the low nibble is separate, a processor can hold a read strobe and step the nibble to stream up to 16 sequential bytes from a single latched upper address.

All strobes are active-high and synchronous to `clk`. The code area and the data area are each 2^REG_AW bytes and aligned to their own size, at base addresses `CODE_BASE` (default 0x00100) and `DATA_BASE` (default 0x00800).

Top module: `mbus_slave`

## Requirements
- R1: In the cycle after any cycle with `rst` high, `ad_oe` is 2'b00 and `ad_out` is 16'h0000.
- R2: The bus width is taken from `wide_mode` (1 = 16-bit, 0 = 8-bit) while `rst` is high. Changes on `wide_mode` after reset have no effect until the next reset.
- R3: While `ale` is high at a clock edge, the upper address is loaded from `ad_in`, and it holds when `ale` is low. In 16-bit mode `ad_in[15:0]` become A[19:4]. In 8-bit mode `ad_in[7:0]` become A[11:4], A[19:12] are zero and `ad_in[15:8]` are ignored. A[3:0] always come from `addr_lo` as sampled in the current cycle.
- R4: When `code_rd` is high at an edge and the address lies in the code area, the next cycle presents code bytes. The byte at area offset k is (7*k + 0x3C) mod 256.
- R5: A read presents its result one cycle after the strobe is sampled. In 16-bit mode it presents the word {byte at A|1, byte at A&~1} with `ad_oe`=2'b11, and A[0] is ignored. In 8-bit mode it presents the byte at A on `ad_out[7:0]`, with `ad_out[15:8]`=0 and `ad_oe`=2'b01. `ad_oe[0]` enables the low lane and `ad_oe[1]` enables the high lane. `data_rd` reads the data area and returns what was last written there. `code_rd` takes priority if both strobes are high.
- R6: While a read strobe stays high, every change of `addr_lo` is reflected on `ad_out` one cycle later, with no new `ale` pulse.
- R7: A write takes the address and `ad_in` from the last cycle in which `data_wr` was high. It is committed at the edge where `data_wr` is first sampled low again.
- R8: In 16-bit mode the write lanes are selected by {`hi_en`, A[0]}. 10 writes both bytes, 11 writes the high byte from `ad_in[15:8]` to the odd address, 00 writes the low byte from `ad_in[7:0]` to the even address, and 01 writes nothing.
- R9: In 8-bit mode a write stores `ad_in[7:0]` at byte address A, and `hi_en` is ignored.
- R10: After a cycle with neither read strobe high, or with a read strobe whose address is outside that strobe's area, `ad_oe` is 2'b00 and `ad_out` is 0.
- R11: A write to an address outside the data area changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also samples `wide_mode` |
| wide_mode | input | 1 | Bus width select: 1 = 16-bit, 0 = 8-bit |
| ale | input | 1 | Address latch strobe for the multiplexed upper address |
| code_rd | input | 1 | Code fetch strobe |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe, committed on its deassertion |
| hi_en | input | 1 | High byte enable for 16-bit writes |
| addr_lo | input | 4 | Dedicated address bits A[3:0] |
| ad_in | input | 16 | Shared pins as seen by the block: address or write data |
| ad_out | output | 16 | Read data driven toward the shared pins |
| ad_oe | output | 2 | Output enables: bit 0 low byte lane, bit 1 high byte lane |

## Verification
Every read result (data, lane enables and release) is due exactly one clock after the edge that samples the strobe and `addr_lo`. The bench therefore changes inputs on the falling edge and checks on the next falling edge, one rising edge later. An `ale` pulse takes effect at the edge that samples it, so reads follow it by at least one edge. A write lands at the second rising edge after the strobe goes up: capture, then commit on the low sample. The bench therefore waits one more falling edge before reading back, so a read never shares an edge with its own commit. Burst steps are checked on every successive falling edge while the strobe stays high.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int unsigned BUS_W = 16;
  localparam int unsigned LO_W  = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CODE = 2'd1,
    SRC_DATA = 2'd2
  } rd_src_e;

  // Fixed pattern held in the code area: byte at offset k.
  function automatic logic [7:0] code_byte(input logic [15:0] off);
    logic [15:0] t;
    t = off * 16'd7 + 16'h003C;
    return t[7:0];
  endfunction

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
  import mbus_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode_i,
  input  logic                ale_i,
  input  logic [BUS_W-1:0]    ad_i,
  input  logic [LO_W-1:0]     lo_i,
  output logic                wide_q,
  output logic [AW-LO_W-1:0]  hi_q,
  output logic [AW-1:0]       addr_o
);

  localparam int unsigned HI_W     = AW - LO_W;
  localparam int unsigned NARROW_W = 8;

  logic [HI_W-1:0] hi_wide;
  logic [HI_W-1:0] hi_narrow;

  assign hi_wide   = ad_i[HI_W-1:0];
  assign hi_narrow = {{(HI_W-NARROW_W){1'b0}}, ad_i[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= wide_mode_i;
      hi_q   <= '0;
    end else if (ale_i) begin
      hi_q <= wide_q ? hi_wide : hi_narrow;
    end
  end

  assign addr_o = {hi_q, lo_i};

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode #(
  parameter int unsigned AW        = 20,
  parameter int unsigned REG_AW    = 8,
  parameter logic [AW-1:0] CODE_BASE = 20'h00100,
  parameter logic [AW-1:0] DATA_BASE = 20'h00800
) (
  input  logic                 code_rd_i,
  input  logic                 data_rd_i,
  input  logic [AW-REG_AW-1:0] rd_page_i,
  input  logic                 commit_i,
  input  logic [AW-REG_AW-1:0] wr_page_i,
  input  logic                 wr_a0_i,
  input  logic                 wr_hien_i,
  input  logic                 wide_i,
  output logic                 code_sel_o,
  output logic                 data_sel_o,
  output logic [1:0]           wr_be_o
);

  localparam int unsigned PG_W = AW - REG_AW;
  localparam logic [PG_W-1:0] CODE_PG = CODE_BASE[AW-1:REG_AW];
  localparam logic [PG_W-1:0] DATA_PG = DATA_BASE[AW-1:REG_AW];

  logic rd_in_code, rd_in_data, wr_in_data;
  logic [1:0] lanes;

  assign rd_in_code = (rd_page_i == CODE_PG);
  assign rd_in_data = (rd_page_i == DATA_PG);
  assign wr_in_data = (wr_page_i == DATA_PG);

  assign code_sel_o = code_rd_i & rd_in_code;
  assign data_sel_o = data_rd_i & ~code_rd_i & rd_in_data;

  always_comb begin
    if (wide_i) lanes = {wr_hien_i, ~wr_a0_i};
    else        lanes = {wr_a0_i, ~wr_a0_i};
    wr_be_o = (commit_i & wr_in_data) ? lanes : 2'b00;
  end

endmodule

// File: rtl/mbus_code_rom.sv
module mbus_code_rom
  import mbus_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk,
  input  logic              re_i,
  input  logic [REG_AW-2:0] widx_i,
  output logic [BUS_W-1:0]  rdata_o
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [15:0] off;
    assign off = 16'({widx_i, 1'(g)});
    always_ff @(posedge clk) begin
      if (re_i) rdata_o[g*8 +: 8] <= code_byte(off);
    end
  end

endmodule

// File: rtl/mbus_data_ram.sv
module mbus_data_ram
  import mbus_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic [1:0]       we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [BUS_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i[g]) mem[widx_i] <= wdata_i[g*8 +: 8];
    end
    always_ff @(posedge clk) begin
      if (re_i) rdata_o[g*8 +: 8] <= mem[ridx_i];
    end
  end

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int unsigned   AW        = 20,
  parameter int unsigned   REG_AW    = 8,
  parameter logic [AW-1:0] CODE_BASE = 20'h00100,
  parameter logic [AW-1:0] DATA_BASE = 20'h00800
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wide_mode,
  input  logic        ale,
  input  logic        code_rd,
  input  logic        data_rd,
  input  logic        data_wr,
  input  logic        hi_en,
  input  logic [3:0]  addr_lo,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic [1:0]  ad_oe
);

  localparam int unsigned HI_W  = AW - LO_W;
  localparam int unsigned PG_W  = AW - REG_AW;
  localparam int unsigned IDX_W = REG_AW - 1;

  logic            wide_q;
  logic [HI_W-1:0] hi_q;
  logic [AW-1:0]   addr;

  // Write capture: values from the last cycle the strobe was high.
  logic            wr_q;
  logic [AW-1:0]   wr_addr_q;
  logic [15:0]     wr_data_q;
  logic            wr_hien_q;
  logic            commit;

  logic            code_sel, data_sel;
  logic [1:0]      wr_be;
  logic [15:0]     wdata;
  logic [15:0]     rom_q, ram_q;

  rd_src_e         src_q;
  logic            a0_q;
  logic [15:0]     word;

  mbus_addr_latch #(.AW(AW)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .wide_mode_i (wide_mode),
    .ale_i       (ale),
    .ad_i        (ad_in),
    .lo_i        (addr_lo),
    .wide_q      (wide_q),
    .hi_q        (hi_q),
    .addr_o      (addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_hien_q <= 1'b0;
    end else begin
      wr_q <= data_wr;
      if (data_wr) begin
        wr_addr_q <= addr;
        wr_data_q <= ad_in;
        wr_hien_q <= hi_en;
      end
    end
  end

  assign commit = wr_q & ~data_wr;

  mbus_decode #(
    .AW        (AW),
    .REG_AW    (REG_AW),
    .CODE_BASE (CODE_BASE),
    .DATA_BASE (DATA_BASE)
  ) u_decode (
    .code_rd_i  (code_rd),
    .data_rd_i  (data_rd),
    .rd_page_i  (addr[AW-1:REG_AW]),
    .commit_i   (commit),
    .wr_page_i  (wr_addr_q[AW-1:REG_AW]),
    .wr_a0_i    (wr_addr_q[0]),
    .wr_hien_i  (wr_hien_q),
    .wide_i     (wide_q),
    .code_sel_o (code_sel),
    .data_sel_o (data_sel),
    .wr_be_o    (wr_be)
  );

  // In 8-bit mode both banks see the low data byte; the lane enable picks one.
  assign wdata = wide_q ? wr_data_q : {wr_data_q[7:0], wr_data_q[7:0]};

  mbus_data_ram #(.IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .we_i    (wr_be),
    .widx_i  (wr_addr_q[REG_AW-1:1]),
    .wdata_i (wdata),
    .re_i    (data_sel),
    .ridx_i  (addr[REG_AW-1:1]),
    .rdata_o (ram_q)
  );

  mbus_code_rom #(.REG_AW(REG_AW)) u_rom (
    .clk     (clk),
    .re_i    (code_sel),
    .widx_i  (addr[REG_AW-1:1]),
    .rdata_o (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_NONE;
      a0_q  <= 1'b0;
    end else begin
      a0_q <= addr[0];
      if (code_sel)      src_q <= SRC_CODE;
      else if (data_sel) src_q <= SRC_DATA;
      else               src_q <= SRC_NONE;
    end
  end

  assign word = (src_q == SRC_CODE) ? rom_q : ram_q;

  always_comb begin
    ad_out = 16'h0000;
    ad_oe  = 2'b00;
    if (src_q != SRC_NONE) begin
      if (wide_q) begin
        ad_out = word;
        ad_oe  = 2'b11;
      end else begin
        ad_out = {8'h00, a0_q ? word[15:8] : word[7:0]};
        ad_oe  = 2'b01;
      end
    end
  end

endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk #(
  parameter int unsigned HI_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            code_rd,
  input logic            data_rd,
  input logic [15:0]     ad_out,
  input logic [1:0]      ad_oe,
  input logic [HI_W-1:0] hi_q,
  input logic            wide_q
);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (ad_oe == 2'b00));

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(wide_q));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(hi_q));

  // R5
  wide_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe == 2'b11) |-> wide_q);

  // R5
  narrow_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe == 2'b01) |-> !wide_q);

  // R5
  lane_code_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe != 2'b10);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(code_rd || data_rd) |=> (ad_oe == 2'b00));

  // R10
  quiet_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe == 2'b00) |-> (ad_out == 16'h0000));

endmodule

bind mbus_slave mbus_slave_chk #(.HI_W(AW - 4)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ale     (ale),
  .code_rd (code_rd),
  .data_rd (data_rd),
  .ad_out  (ad_out),
  .ad_oe   (ad_oe),
  .hi_q    (hi_q),
  .wide_q  (wide_q)
);

// File: tb/mbus_slave_tb.sv
module mbus_slave_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        ale = 1'b0;
  logic        code_rd = 1'b0;
  logic        data_rd = 1'b0;
  logic        data_wr = 1'b0;
  logic        hi_en = 1'b0;
  logic [3:0]  addr_lo = 4'h0;
  logic [15:0] ad_in = 16'h0000;
  logic [15:0] ad_out;
  logic [1:0]  ad_oe;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  mbus_slave u_dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .ale(ale),
    .code_rd(code_rd), .data_rd(data_rd), .data_wr(data_wr),
    .hi_en(hi_en), .addr_lo(addr_lo), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  function automatic logic [7:0] cb(input int k);
    return 8'((k * 7 + 60) & 255);
  endfunction

  task automatic expect_bus(input string req, input logic [15:0] exp_d,
                            input logic [1:0] exp_oe);
    vectors++;
    if (ad_out !== exp_d || ad_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: ad_out=%h ad_oe=%b expected ad_out=%h ad_oe=%b",
               req, ad_out, ad_oe, exp_d, exp_oe);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1; wide_mode = mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic latch(input logic [15:0] pins);
    ale = 1'b1; ad_in = pins;
    @(negedge clk);
    ale = 1'b0; ad_in = 16'h0000;
  endtask

  // Issue a read strobe for one cycle and check the result one edge later.
  task automatic rd_once(input bit code, input logic [3:0] lo, input string req,
                         input logic [15:0] exp_d, input logic [1:0] exp_oe);
    code_rd = code; data_rd = !code; addr_lo = lo;
    @(negedge clk);
    expect_bus(req, exp_d, exp_oe);
    code_rd = 1'b0; data_rd = 1'b0;
    @(negedge clk);
    expect_bus("R10 release", 16'h0000, 2'b00);
  endtask

  // Strobe high for two cycles with changing data; the last value must win (R7).
  task automatic wr(input logic [3:0] lo, input logic [15:0] d, input logic he);
    data_wr = 1'b1; addr_lo = lo; hi_en = he; ad_in = ~d;
    @(negedge clk);
    ad_in = d;
    @(negedge clk);
    data_wr = 1'b0; ad_in = 16'h0000; hi_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    expect_bus("R1 reset", 16'h0000, 2'b00);
  endtask

  task automatic t_narrow_code;
    latch(16'hFF10);   // R3: upper pins ignored in 8-bit mode -> A = 0x10x
    rd_once(1'b1, 4'h5, "R4 narrow code", {8'h00, cb(5)}, 2'b01);
  endtask

  task automatic t_narrow_burst;
    latch(16'h0010);
    code_rd = 1'b1;
    for (int i = 0; i < 16; i++) begin
      addr_lo = 4'(i);
      @(negedge clk);
      expect_bus("R6 narrow burst", {8'h00, cb(i)}, 2'b01);
    end
    code_rd = 1'b0;
    @(negedge clk);
    expect_bus("R10 release", 16'h0000, 2'b00);
  endtask

  task automatic t_narrow_write;
    latch(16'h0080);
    wr(4'h3, 16'h55A7, 1'b1);   // R9: hi_en ignored, low byte stored
    wr(4'h4, 16'h005E, 1'b0);
    rd_once(1'b0, 4'h3, "R7 R9 narrow write odd", 16'h00A7, 2'b01);
    rd_once(1'b0, 4'h4, "R9 narrow write even", 16'h005E, 2'b01);
  endtask

  task automatic t_windows;
    latch(16'h0010);
    rd_once(1'b0, 4'h3, "R10 data strobe in code area", 16'h0000, 2'b00);
    latch(16'h0080);
    rd_once(1'b1, 4'h3, "R10 code strobe in data area", 16'h0000, 2'b00);
    latch(16'h0090);
    wr(4'h3, 16'h00EE, 1'b0);
    latch(16'h0080);
    rd_once(1'b0, 4'h3, "R11 outside write", 16'h00A7, 2'b01);
  endtask

  task automatic t_mode_hold;
    do_reset(1'b1);
    wide_mode = 1'b0;   // R2: must be ignored after reset
    repeat (2) @(negedge clk);
    latch(16'h0010);
    rd_once(1'b1, 4'h6, "R2 R4 wide code", {cb(7), cb(6)}, 2'b11);
    rd_once(1'b1, 4'h7, "R5 A0 ignored", {cb(7), cb(6)}, 2'b11);
    latch(16'h1010);    // R3: A[19:12] used in 16-bit mode
    rd_once(1'b1, 4'h6, "R3 wide upper bits", 16'h0000, 2'b00);
  endtask

  task automatic t_wide_burst;
    latch(16'h0010);
    code_rd = 1'b1;
    for (int i = 0; i < 16; i++) begin
      addr_lo = 4'(i);
      @(negedge clk);
      expect_bus("R6 wide burst", {cb(i | 1), cb(i & 14)}, 2'b11);
    end
    code_rd = 1'b0;
    @(negedge clk);
    expect_bus("R10 release", 16'h0000, 2'b00);
  endtask

  task automatic t_wide_bytes;
    latch(16'h0080);
    wr(4'h0, 16'h1234, 1'b1);
    rd_once(1'b0, 4'h0, "R8 word", 16'h1234, 2'b11);
    wr(4'h1, 16'hAB00, 1'b1);
    rd_once(1'b0, 4'h0, "R8 high byte", 16'hAB34, 2'b11);
    wr(4'h0, 16'h00CD, 1'b0);
    rd_once(1'b0, 4'h0, "R8 low byte", 16'hABCD, 2'b11);
    wr(4'h1, 16'hFFFF, 1'b0);
    rd_once(1'b0, 4'h1, "R8 no lanes", 16'hABCD, 2'b11);
  endtask

  initial begin
    t_reset();
    t_narrow_code();
    t_narrow_burst();
    t_narrow_write();
    t_windows();
    t_mode_hold();
    t_wide_burst();
    t_wide_bytes();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule